// File: doc/BRIEF.md
# Tagged Stack Register File

This block holds eight 80-bit registers for a floating-point unit. Commands address the registers relative to a 3-bit top-of-stack pointer: ST0 is the physical register the pointer selects, and ST(i) is physical register (top + i) mod 8. Each physical register has a 2-bit tag, 11 for empty and 00 for valid. A push moves the pointer down one slot and a pop moves it up one slot, so no data is copied. A push onto an occupied slot raises a one-cycle overflow flag. A read or pop of an empty slot raises a one-cycle underflow flag. In both fault cases the state does not change.

A second port, for packed-integer instructions, ignores the pointer and addresses physical registers directly. It reads and writes the low 64 bits of a register, which is the significand field. Every access through this port marks all eight tags valid. A write through it also sets the upper 16 bits of the target register to ones and returns the pointer to 0. When an access on this port and a stack command arrive in the same cycle, the port access takes effect and the stack command is dropped.

All outputs are registered. Read data and the fault flags appear one clock after the command that caused them.

Top module: `fpst_stack_regs`

## Requirements
- R1: After synchronous reset, `top_ptr` is 0, `tag_word` is all ones, and `rd_valid`, `mm_rvalid`, `stk_overflow` and `stk_underflow` are 0. Tag of physical register k sits at `tag_word[2k+1:2k]`.
- R2: Push (cmd_op 1) writes `cmd_wdata` to physical register (top-1) mod 8, tags it 00 and sets top to that register. The previous ST(i) becomes ST(i+1).
- R3: Push whose target slot has a tag other than 11 pulses `stk_overflow` for one cycle and changes no data, tag or pointer.
- R4: Store (cmd_op 3) returns ST0 on `rd_data` with `rd_valid` one cycle later and changes nothing. Store-and-pop (cmd_op 4) returns ST0 the same way, tags that slot 11 and increments top mod 8. Pop (cmd_op 2) does the same as store-and-pop without returning data.
- R5: Pop, store or store-and-pop when ST0 is tagged 11, and a register read of an empty ST(i), each pulse `stk_underflow` for one cycle. No state changes and `rd_valid` stays 0.
- R6: Register read (cmd_op 5) returns ST(`cmd_idx`) one cycle later. Register write (cmd_op 6) stores `cmd_wdata` into ST(`cmd_idx`) and tags it 00, whatever its previous tag.
- R7: Exchange (cmd_op 7) swaps the contents of ST0 and ST(`cmd_idx`). If either of the two slots is empty it signals underflow instead and changes nothing.
- R8: Initialise (cmd_op 8) sets top to 0 and all tags to 11. Empty-all (cmd_op 9) sets all tags to 11 and keeps top.
- R9: Alias read (`mm_en`=1, `mm_we`=0) returns bits 63:0 of physical register `mm_idx` on `mm_rdata` with `mm_rvalid` one cycle later, and sets all tags to 00.
- R10: Alias write (`mm_en`=1, `mm_we`=1) sets bits 63:0 of physical register `mm_idx` to `mm_wdata` and bits 79:64 to all ones, sets all tags to 00 and sets top to 0.
- R11: A stack command issued in the same cycle as an alias access has no effect: no flag, no read data, and no change beyond the alias access itself.
- R12: cmd_op values 0 and 10 to 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Stack command strobe |
| cmd_op | input | 4 | Stack command code |
| cmd_idx | input | 3 | Stack-relative index i for ST(i) |
| cmd_wdata | input | 80 | Value for push and register write |
| mm_en | input | 1 | Alias port access strobe |
| mm_we | input | 1 | Alias port write (1) or read (0) |
| mm_idx | input | 3 | Physical register number for alias port |
| mm_wdata | input | 64 | Alias write data |
| rd_data | output | 80 | Stack read data |
| rd_valid | output | 1 | rd_data carries a result |
| mm_rdata | output | 64 | Alias read data |
| mm_rvalid | output | 1 | mm_rdata carries a result |
| stk_overflow | output | 1 | One-cycle push fault |
| stk_underflow | output | 1 | One-cycle empty-access fault |
| top_ptr | output | 3 | Current top-of-stack pointer |
| tag_word | output | 16 | Tags of all physical registers |

## Verification
Alias port accesses and stack commands can be issued in the same cycle, and this collision gets the closest scrutiny. The bench drives an alias write together with a push, an alias read together with a store, and an alias write together with initialise. In each case it expects only the alias effect, with no fault flag and no stack read data. Later register reads and pointer values then confirm that the dropped command left no trace in the data or in the tags.

// File: rtl/fpst_pkg.sv
`timescale 1ns/1ps
package fpst_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_STORE  = 4'd3,
    OP_STOREP = 4'd4,
    OP_RDI    = 4'd5,
    OP_WRI    = 4'd6,
    OP_XCHG   = 4'd7,
    OP_INIT   = 4'd8,
    OP_EMPTY  = 4'd9
  } stk_op_e;

  typedef enum logic [1:0] {
    SRC_CMD   = 2'd0,
    SRC_PEER  = 2'd1,
    SRC_ALIAS = 2'd2
  } wsrc_e;

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;

endpackage

// File: rtl/fpst_ctrl.sv
`timescale 1ns/1ps
// Command decode: turns the command, the pointer and the tags into
// write-port, tag, pointer and fault actions for one cycle.
module fpst_ctrl
  import fpst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                  cmd_valid,
  input  stk_op_e               cmd_op,
  input  logic [PW-1:0]         cmd_idx,
  input  logic [PW-1:0]         top,
  input  logic [DEPTH-1:0][1:0] tags,
  input  logic                  mm_en,
  input  logic                  mm_we,
  input  logic [PW-1:0]         mm_idx,
  output logic                  top_we,
  output logic [PW-1:0]         top_nxt,
  output logic                  tag_clr_all,
  output logic                  tag_val_all,
  output logic                  tag_set_en,
  output logic [PW-1:0]         tag_set_addr,
  output logic [1:0]            tag_set_val,
  output logic                  wa_en,
  output logic [PW-1:0]         wa_addr,
  output wsrc_e                 wa_src,
  output logic                  wb_en,
  output logic [PW-1:0]         wb_addr,
  output logic [PW-1:0]         rb_addr,
  output logic                  rd_en,
  output logic                  rd_from_b,
  output logic                  mm_rd,
  output logic                  ovf,
  output logic                  unf
);

  logic [PW-1:0] p0, pi, pp;
  logic          e0, ei;

  // Pointer arithmetic wraps at DEPTH (DEPTH is a power of two).
  assign p0 = top;
  assign pi = top + cmd_idx;
  assign pp = top - PW'(1);
  assign e0 = (tags[p0] == TAG_EMPTY);
  assign ei = (tags[pi] == TAG_EMPTY);

  assign rb_addr = mm_en ? mm_idx : pi;

  always_comb begin
    top_we       = 1'b0;
    top_nxt      = '0;
    tag_clr_all  = 1'b0;
    tag_val_all  = 1'b0;
    tag_set_en   = 1'b0;
    tag_set_addr = p0;
    tag_set_val  = TAG_VALID;
    wa_en        = 1'b0;
    wa_addr      = p0;
    wa_src       = SRC_CMD;
    wb_en        = 1'b0;
    wb_addr      = pi;
    rd_en        = 1'b0;
    rd_from_b    = 1'b0;
    mm_rd        = 1'b0;
    ovf          = 1'b0;
    unf          = 1'b0;
    if (mm_en) begin
      // Alias port owns the cycle; any stack command is dropped.
      tag_val_all = 1'b1;
      if (mm_we) begin
        wa_en   = 1'b1;
        wa_addr = mm_idx;
        wa_src  = SRC_ALIAS;
        top_we  = 1'b1;
        top_nxt = '0;
      end else begin
        mm_rd = 1'b1;
      end
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_PUSH: begin
          if (tags[pp] != TAG_EMPTY) begin
            ovf = 1'b1;
          end else begin
            wa_en        = 1'b1;
            wa_addr      = pp;
            tag_set_en   = 1'b1;
            tag_set_addr = pp;
            top_we       = 1'b1;
            top_nxt      = pp;
          end
        end
        OP_POP, OP_STOREP: begin
          if (e0) begin
            unf = 1'b1;
          end else begin
            tag_set_en   = 1'b1;
            tag_set_addr = p0;
            tag_set_val  = TAG_EMPTY;
            top_we       = 1'b1;
            top_nxt      = p0 + PW'(1);
            rd_en        = (cmd_op == OP_STOREP);
          end
        end
        OP_STORE: begin
          if (e0) unf = 1'b1;
          else    rd_en = 1'b1;
        end
        OP_RDI: begin
          if (ei) begin
            unf = 1'b1;
          end else begin
            rd_en     = 1'b1;
            rd_from_b = 1'b1;
          end
        end
        OP_WRI: begin
          wa_en        = 1'b1;
          wa_addr      = pi;
          tag_set_en   = 1'b1;
          tag_set_addr = pi;
        end
        OP_XCHG: begin
          if (e0 || ei) begin
            unf = 1'b1;
          end else begin
            wa_en   = 1'b1;
            wa_addr = p0;
            wa_src  = SRC_PEER;
            wb_en   = 1'b1;
          end
        end
        OP_INIT: begin
          top_we      = 1'b1;
          top_nxt     = '0;
          tag_clr_all = 1'b1;
        end
        OP_EMPTY: begin
          tag_clr_all = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fpst_tags.sv
`timescale 1ns/1ps
// Per-register 2-bit tags with whole-file set/clear and a single-slot update.
module fpst_tags
  import fpst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_all,
  input  logic                  val_all,
  input  logic                  set_en,
  input  logic [PW-1:0]         set_addr,
  input  logic [1:0]            set_val,
  output logic [DEPTH-1:0][1:0] tags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) tags[k] <= TAG_EMPTY;
    end else if (clr_all) begin
      for (int k = 0; k < DEPTH; k++) tags[k] <= TAG_EMPTY;
    end else if (val_all) begin
      for (int k = 0; k < DEPTH; k++) tags[k] <= TAG_VALID;
    end else if (set_en) begin
      tags[set_addr] <= set_val;
    end
  end

endmodule

// File: rtl/fpst_data.sv
`timescale 1ns/1ps
// Register array: two write ports (exchange writes both slots at once),
// two asynchronous read ports. No reset on the storage.
module fpst_data #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wa_en,
  input  logic [PW-1:0]    wa_addr,
  input  logic [WIDTH-1:0] wa_din,
  input  logic             wb_en,
  input  logic [PW-1:0]    wb_addr,
  input  logic [WIDTH-1:0] wb_din,
  input  logic [PW-1:0]    ra_addr,
  output logic [WIDTH-1:0] ra_q,
  input  logic [PW-1:0]    rb_addr,
  output logic [WIDTH-1:0] rb_q
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wb_en) mem[wb_addr] <= wb_din;
    if (wa_en) mem[wa_addr] <= wa_din;
  end

  assign ra_q = mem[ra_addr];
  assign rb_q = mem[rb_addr];

endmodule

// File: rtl/fpst_stack_regs.sv
`timescale 1ns/1ps
module fpst_stack_regs
  import fpst_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 80,
  parameter int ALIAS_W = 64,
  localparam int PW     = $clog2(DEPTH),
  localparam int HIGH_W = WIDTH - ALIAS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_op,
  input  logic [PW-1:0]      cmd_idx,
  input  logic [WIDTH-1:0]   cmd_wdata,
  input  logic               mm_en,
  input  logic               mm_we,
  input  logic [PW-1:0]      mm_idx,
  input  logic [ALIAS_W-1:0] mm_wdata,
  output logic [WIDTH-1:0]   rd_data,
  output logic               rd_valid,
  output logic [ALIAS_W-1:0] mm_rdata,
  output logic               mm_rvalid,
  output logic               stk_overflow,
  output logic               stk_underflow,
  output logic [PW-1:0]      top_ptr,
  output logic [2*DEPTH-1:0] tag_word
);

  stk_op_e               op_e;
  logic [DEPTH-1:0][1:0] tags_q;
  logic                  top_we, tag_clr_all, tag_val_all, tag_set_en;
  logic [PW-1:0]         top_nxt, tag_set_addr, wa_addr, wb_addr, rb_addr;
  logic [1:0]            tag_set_val;
  logic                  wa_en, wb_en, rd_en, rd_from_b, mm_rd, ovf_c, unf_c;
  wsrc_e                 wa_src;
  logic [WIDTH-1:0]      wa_din, ra_q, rb_q;

  assign op_e = stk_op_e'(cmd_op);

  fpst_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .cmd_valid    (cmd_valid),
    .cmd_op       (op_e),
    .cmd_idx      (cmd_idx),
    .top          (top_ptr),
    .tags         (tags_q),
    .mm_en        (mm_en),
    .mm_we        (mm_we),
    .mm_idx       (mm_idx),
    .top_we       (top_we),
    .top_nxt      (top_nxt),
    .tag_clr_all  (tag_clr_all),
    .tag_val_all  (tag_val_all),
    .tag_set_en   (tag_set_en),
    .tag_set_addr (tag_set_addr),
    .tag_set_val  (tag_set_val),
    .wa_en        (wa_en),
    .wa_addr      (wa_addr),
    .wa_src       (wa_src),
    .wb_en        (wb_en),
    .wb_addr      (wb_addr),
    .rb_addr      (rb_addr),
    .rd_en        (rd_en),
    .rd_from_b    (rd_from_b),
    .mm_rd        (mm_rd),
    .ovf          (ovf_c),
    .unf          (unf_c)
  );

  fpst_tags #(.DEPTH(DEPTH), .PW(PW)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (tag_clr_all),
    .val_all  (tag_val_all),
    .set_en   (tag_set_en),
    .set_addr (tag_set_addr),
    .set_val  (tag_set_val),
    .tags     (tags_q)
  );

  always_comb begin
    case (wa_src)
      SRC_PEER:  wa_din = rb_q;
      SRC_ALIAS: wa_din = {{HIGH_W{1'b1}}, mm_wdata};
      default:   wa_din = cmd_wdata;
    endcase
  end

  fpst_data #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_data (
    .clk     (clk),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_din  (wa_din),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_din  (ra_q),
    .ra_addr (top_ptr),
    .ra_q    (ra_q),
    .rb_addr (rb_addr),
    .rb_q    (rb_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      top_ptr       <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      mm_rvalid     <= 1'b0;
      mm_rdata      <= '0;
      stk_overflow  <= 1'b0;
      stk_underflow <= 1'b0;
    end else begin
      if (top_we) top_ptr <= top_nxt;
      rd_valid      <= rd_en;
      mm_rvalid     <= mm_rd;
      stk_overflow  <= ovf_c;
      stk_underflow <= unf_c;
      if (rd_en) rd_data  <= rd_from_b ? rb_q : ra_q;
      if (mm_rd) mm_rdata <= rb_q[ALIAS_W-1:0];
    end
  end

  assign tag_word = tags_q;

endmodule

// File: rtl/fpst_stack_chk.sv
`timescale 1ns/1ps
module fpst_stack_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [3:0]         cmd_op,
  input logic               mm_en,
  input logic               mm_we,
  input logic [PW-1:0]      top_ptr,
  input logic [2*DEPTH-1:0] tag_word,
  input logic               stk_overflow,
  input logic               stk_underflow,
  input logic               rd_valid
);

  logic stk_cmd;
  assign stk_cmd = cmd_valid && !mm_en;

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (top_ptr == '0 && tag_word == '1 && !rd_valid));

  assert_push_moves_top_R2: assert property (@(posedge clk) disable iff (rst)
    (stk_cmd && cmd_op == 4'd1) |=>
      (stk_overflow || top_ptr == PW'($past(top_ptr) - 1'b1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    stk_overflow |-> ($past(stk_cmd && cmd_op == 4'd1) &&
                      $stable(top_ptr) && $stable(tag_word)));

  assert_read_source_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(stk_cmd && (cmd_op == 4'd3 || cmd_op == 4'd4 ||
                                   cmd_op == 4'd5)));

  assert_underflow_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    stk_underflow |-> ($stable(top_ptr) && $stable(tag_word) && !rd_valid));

  assert_empty_all_R8: assert property (@(posedge clk) disable iff (rst)
    (stk_cmd && cmd_op == 4'd9) |=> (tag_word == '1));

  assert_alias_tags_R9: assert property (@(posedge clk) disable iff (rst)
    mm_en |=> (tag_word == '0));

  assert_alias_write_top_R10: assert property (@(posedge clk) disable iff (rst)
    (mm_en && mm_we) |=> (top_ptr == '0));

  assert_collision_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (mm_en && cmd_valid) |=> (!stk_overflow && !stk_underflow && !rd_valid));

endmodule

bind fpst_stack_regs fpst_stack_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .mm_en         (mm_en),
  .mm_we         (mm_we),
  .top_ptr       (top_ptr),
  .tag_word      (tag_word),
  .stk_overflow  (stk_overflow),
  .stk_underflow (stk_underflow),
  .rd_valid      (rd_valid)
);

// File: tb/sim_fpst_stack_regs.sv
`timescale 1ns/1ps
module sim_fpst_stack_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] cmd_wdata = '0;
  logic        mm_en = 1'b0;
  logic        mm_we = 1'b0;
  logic [2:0]  mm_idx = '0;
  logic [63:0] mm_wdata = '0;
  logic [79:0] rd_data;
  logic        rd_valid;
  logic [63:0] mm_rdata;
  logic        mm_rvalid;
  logic        stk_overflow, stk_underflow;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;

  int checks = 0;
  int errors = 0;

  // reference state built from the requirements
  logic [79:0] m  [8];
  logic [1:0]  mt [8];
  logic [2:0]  mtop;

  always #2.5 clk = ~clk;

  fpst_stack_regs u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .mm_en(mm_en), .mm_we(mm_we),
    .mm_idx(mm_idx), .mm_wdata(mm_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
    .stk_overflow(stk_overflow), .stk_underflow(stk_underflow),
    .top_ptr(top_ptr), .tag_word(tag_word)
  );

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_tags();
    logic [15:0] w;
    for (int k = 0; k < 8; k++) w[2*k +: 2] = mt[k];
    return w;
  endfunction

  task automatic step(input logic cv, input logic [3:0] op, input logic [2:0] idx,
                      input logic [79:0] wd, input logic me, input logic mw,
                      input logic [2:0] mi, input logic [63:0] mwd,
                      input string req);
    logic        e_rv, e_ovf, e_unf, e_mv;
    logic [79:0] e_rd, tmp;
    logic [63:0] e_md;
    logic [2:0]  p0, pi, pp;
    e_rv = 0; e_ovf = 0; e_unf = 0; e_mv = 0; e_rd = '0; e_md = '0;
    p0 = mtop; pi = mtop + idx; pp = mtop - 3'd1;
    cmd_valid = cv; cmd_op = op; cmd_idx = idx; cmd_wdata = wd;
    mm_en = me; mm_we = mw; mm_idx = mi; mm_wdata = mwd;
    if (me) begin
      if (mw) begin
        m[mi] = {16'hFFFF, mwd};
        mtop = 3'd0;
      end else begin
        e_mv = 1; e_md = m[mi][63:0];
      end
      for (int k = 0; k < 8; k++) mt[k] = 2'b00;
    end else if (cv) begin
      case (op)
        4'd1: if (mt[pp] != 2'b11) e_ovf = 1;
              else begin m[pp] = wd; mt[pp] = 2'b00; mtop = pp; end
        4'd2: if (mt[p0] == 2'b11) e_unf = 1;
              else begin mt[p0] = 2'b11; mtop = p0 + 3'd1; end
        4'd3: if (mt[p0] == 2'b11) e_unf = 1;
              else begin e_rv = 1; e_rd = m[p0]; end
        4'd4: if (mt[p0] == 2'b11) e_unf = 1;
              else begin e_rv = 1; e_rd = m[p0]; mt[p0] = 2'b11; mtop = p0 + 3'd1; end
        4'd5: if (mt[pi] == 2'b11) e_unf = 1;
              else begin e_rv = 1; e_rd = m[pi]; end
        4'd6: begin m[pi] = wd; mt[pi] = 2'b00; end
        4'd7: if (mt[p0] == 2'b11 || mt[pi] == 2'b11) e_unf = 1;
              else begin tmp = m[p0]; m[p0] = m[pi]; m[pi] = tmp; end
        4'd8: begin mtop = 3'd0; for (int k = 0; k < 8; k++) mt[k] = 2'b11; end
        4'd9: for (int k = 0; k < 8; k++) mt[k] = 2'b11;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    cmd_valid = 0; mm_en = 0; mm_we = 0;
    chk(req, "rd_valid", 80'(rd_valid), 80'(e_rv));
    if (e_rv) chk(req, "rd_data", rd_data, e_rd);
    chk(req, "mm_rvalid", 80'(mm_rvalid), 80'(e_mv));
    if (e_mv) chk(req, "mm_rdata", 80'(mm_rdata), 80'(e_md));
    chk(req, "overflow", 80'(stk_overflow), 80'(e_ovf));
    chk(req, "underflow", 80'(stk_underflow), 80'(e_unf));
    chk(req, "top_ptr", 80'(top_ptr), 80'(mtop));
    chk(req, "tag_word", 80'(tag_word), 80'(exp_tags()));
  endtask

  task automatic cmd(input logic [3:0] op, input logic [2:0] idx,
                     input logic [79:0] wd, input string req);
    step(1'b1, op, idx, wd, 1'b0, 1'b0, 3'd0, 64'd0, req);
  endtask

  task automatic alias_acc(input logic we, input logic [2:0] n,
                           input logic [63:0] d, input string req);
    step(1'b0, 4'd0, 3'd0, 80'd0, 1'b1, we, n, d, req);
  endtask

  function automatic logic [79:0] pat(input int k);
    return {16'(16'h3F00 + k), 64'hC0DE_0000_0000_0000 | 64'(k * 64'h1_0001)};
  endfunction

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) begin m[k] = '0; mt[k] = 2'b11; end
    mtop = 3'd0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    chk("R1", "top_ptr", 80'(top_ptr), 80'd0);
    chk("R1", "tag_word", 80'(tag_word), 80'hFFFF);
    chk("R1", "flags", 80'({rd_valid, mm_rvalid, stk_overflow, stk_underflow}), 80'd0);

    // R5 / R7 faults on an empty stack
    cmd(4'd2, 3'd0, '0, "R5");
    cmd(4'd3, 3'd0, '0, "R5");
    cmd(4'd4, 3'd0, '0, "R5");
    cmd(4'd5, 3'd3, '0, "R5");
    cmd(4'd7, 3'd2, '0, "R7");

    // R2 fill, R3 overflow on the ninth push
    for (int k = 0; k < 8; k++) cmd(4'd1, 3'd0, pat(k), "R2");
    cmd(4'd1, 3'd0, pat(99), "R3");
    for (int i = 0; i < 8; i++) cmd(4'd5, 3'(i), '0, "R6");

    // R7 exchange with every depth, read back both slots
    for (int i = 0; i < 8; i++) begin
      cmd(4'd7, 3'(i), '0, "R7");
      cmd(4'd5, 3'(i), '0, "R7");
      cmd(4'd3, 3'd0, '0, "R7");
    end

    // R4 store, store-and-pop until empty, then R5
    cmd(4'd3, 3'd0, '0, "R4");
    for (int k = 0; k < 8; k++) cmd(4'd4, 3'd0, '0, "R4");
    cmd(4'd4, 3'd0, '0, "R5");
    cmd(4'd2, 3'd0, '0, "R5");

    // R12 unused codes
    cmd(4'd0, 3'd0, pat(50), "R12");
    for (int c = 10; c < 16; c++) cmd(4'(c), 3'd1, pat(c), "R12");

    // R8 initialise, partial stack, R6 register writes with wrap
    cmd(4'd8, 3'd0, '0, "R8");
    for (int k = 0; k < 3; k++) cmd(4'd1, 3'd0, pat(20 + k), "R2");
    cmd(4'd2, 3'd0, '0, "R4");
    for (int i = 0; i < 8; i++) cmd(4'd6, 3'(i), pat(40 + i), "R6");
    for (int i = 0; i < 8; i++) cmd(4'd5, 3'(i), '0, "R6");
    cmd(4'd9, 3'd0, '0, "R8");
    cmd(4'd5, 3'd0, '0, "R5");
    cmd(4'd1, 3'd0, pat(60), "R8");
    cmd(4'd8, 3'd0, '0, "R8");

    // R10 alias writes, R9 alias reads, stack view of the result
    for (int n = 0; n < 8; n++) begin
      cmd(4'd1, 3'd0, pat(70 + n), "R10");
      alias_acc(1'b1, 3'(n), 64'h0123_4567_0000_0000 + 64'(n), "R10");
    end
    for (int n = 0; n < 8; n++) alias_acc(1'b0, 3'(n), '0, "R9");
    for (int i = 0; i < 8; i++) cmd(4'd5, 3'(i), '0, "R10");
    cmd(4'd1, 3'd0, pat(80), "R3");

    // R11 collisions of alias accesses with stack commands
    cmd(4'd9, 3'd0, '0, "R8");
    cmd(4'd1, 3'd0, pat(90), "R11");
    cmd(4'd1, 3'd0, pat(91), "R11");
    step(1'b1, 4'd1, 3'd0, pat(92), 1'b1, 1'b1, 3'd5, 64'hFACE, "R11");
    step(1'b1, 4'd3, 3'd0, '0, 1'b1, 1'b0, 3'd6, 64'd0, "R11");
    step(1'b1, 4'd8, 3'd0, '0, 1'b1, 1'b1, 3'd2, 64'hBEEF, "R11");
    step(1'b1, 4'd9, 3'd0, '0, 1'b1, 1'b0, 3'd2, 64'd0, "R11");
    for (int i = 0; i < 8; i++) cmd(4'd5, 3'(i), '0, "R11");
    cmd(4'd3, 3'd0, '0, "R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule